// File: doc/BRIEF.md
# Conditional Trap Comparator

This block decides whether a conditional trap instruction fires. It compares two operands, A and B, and tests five relations between them: signed less-than, signed greater-than, equality, unsigned less-than and unsigned greater-than. A 5-bit condition mask selects which of these relations count. If any selected relation holds, the block requests a trap.

An input selects the compare width. In word mode only the low 32 bits of each operand are compared. In doubleword mode all 64 bits are compared. The second operand arrives already formed; the block does not decode instructions or handle immediates.

The result is registered. For each accepted strobe, one cycle later the block raises a response-valid flag for one cycle. If the request traps, it also raises a single-cycle trap pulse and presents a cause code that the exception entry unit can take directly.

Top module: `tcmp_trap_cmp`

## Requirements
- R1: While reset is held and right after it, `resp_valid_o`, `trap_o` and `trap_cause_o` are all zero.
- R2: Mask bit 4 (value 0x10) traps when A < B compared as two's-complement signed values.
- R3: Mask bit 3 (value 0x08) traps when A > B compared as signed values.
- R4: Mask bit 2 (value 0x04) traps when A equals B.
- R5: Mask bit 1 (value 0x02) traps when A < B compared as unsigned values. Mask bit 0 (value 0x01) traps when A > B compared as unsigned values.
- R6: With `dword_i` = 0 (word mode), bits 63:32 of both operands have no effect. The low 32 bits are compared as signed or unsigned 32-bit numbers.
- R7: With `dword_i` = 1 (doubleword mode), all 64 bits take part, including the sign at bit 63.
- R8: The result appears exactly one clock after a cycle with `req_valid_i` high. `resp_valid_o` is high for that one cycle and `trap_o` is high at most for that cycle. Neither is ever high without a strobe in the previous cycle.
- R9: While `trap_o` is high, `trap_cause_o` is 8'h62: class 4'h6 (program check) in bits 7:4 and sub-cause 4'h2 (trap) in bits 3:0. At all other times it is 8'h00.
- R10: A mask of zero never traps. A mask of all ones (0x1F) always traps.
- R11: `rel_hits_o` equals the mask ANDed with the five relation results of the latest strobe, using the bit positions above. It holds that value until the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Evaluate strobe |
| dword_i | input | 1 | 1 = 64-bit compare, 0 = 32-bit compare |
| cond_mask_i | input | 5 | Relation select mask |
| op_a_i | input | 64 | First operand |
| op_b_i | input | 64 | Second operand |
| resp_valid_o | output | 1 | Result of previous-cycle strobe is present |
| trap_o | output | 1 | One-cycle trap request |
| trap_cause_o | output | 8 | Exception class and sub-cause |
| rel_hits_o | output | 5 | Selected relations that held |

## Verification
A new strobe can arrive in the same cycle in which the result register is driving the previous trap pulse. The new evaluation reloads the register while the old pulse is still on the output. The bench provokes this by issuing strobes back to back, with random and directed operands, and mixing trapping and non-trapping requests. Each cycle's pulse, cause and hit vector must match the strobe issued one cycle before. A trapping request followed by a non-trapping one must leave `trap_o` low in the second result cycle, which shows that no pulse is stretched across adjacent requests.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  localparam int REL_W = 5;
  // relation bit positions inside the mask and the hit vector
  localparam int REL_UGT = 0;
  localparam int REL_ULT = 1;
  localparam int REL_EQ  = 2;
  localparam int REL_SGT = 3;
  localparam int REL_SLT = 4;

  localparam logic [3:0] CLASS_PROGRAM = 4'h6;
  localparam logic [3:0] SUB_TRAP      = 4'h2;

  typedef struct packed {
    logic [3:0] cls;
    logic [3:0] sub;
  } trap_cause_t;
endpackage

// File: rtl/tcmp_operand_fmt.sv
module tcmp_operand_fmt #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  logic              dword_i,
  input  logic [DATA_W-1:0] op_i,
  output logic [DATA_W:0]   sx_o,
  output logic [DATA_W:0]   zx_o
);
  localparam int PAD_W = DATA_W + 1 - WORD_W;

  always_comb begin
    if (dword_i) begin
      sx_o = {op_i[DATA_W-1], op_i};
      zx_o = {1'b0, op_i};
    end else begin
      sx_o = {{PAD_W{op_i[WORD_W-1]}}, op_i[WORD_W-1:0]};
      zx_o = {{PAD_W{1'b0}}, op_i[WORD_W-1:0]};
    end
  end
endmodule

// File: rtl/tcmp_relation_unit.sv
module tcmp_relation_unit
  import tcmp_pkg::*;
#(
  parameter int EXT_W = 65
) (
  input  logic [EXT_W-1:0] a_sx_i,
  input  logic [EXT_W-1:0] b_sx_i,
  input  logic [EXT_W-1:0] a_zx_i,
  input  logic [EXT_W-1:0] b_zx_i,
  output logic [REL_W-1:0] rel_o
);
  logic s_lt, s_gt, u_lt, u_gt, eq;

  always_comb begin
    s_lt = $signed(a_sx_i) < $signed(b_sx_i);
    s_gt = $signed(a_sx_i) > $signed(b_sx_i);
    u_lt = a_zx_i < b_zx_i;
    u_gt = a_zx_i > b_zx_i;
    eq   = a_zx_i == b_zx_i;
    rel_o          = '0;
    rel_o[REL_SLT] = s_lt;
    rel_o[REL_SGT] = s_gt;
    rel_o[REL_EQ]  = eq;
    rel_o[REL_ULT] = u_lt;
    rel_o[REL_UGT] = u_gt;
  end
endmodule

// File: rtl/tcmp_result_reg.sv
module tcmp_result_reg
  import tcmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_i,
  input  logic [REL_W-1:0] hits_i,
  output logic             resp_valid_o,
  output logic             trap_o,
  output trap_cause_t      cause_o,
  output logic [REL_W-1:0] hits_o
);
  logic             valid_d, valid_q;
  logic             trap_d, trap_q;
  trap_cause_t      cause_d, cause_q;
  logic [REL_W-1:0] hits_q;
  logic             hits_en;

  always_comb begin
    hits_en = strobe_i;
    valid_d = strobe_i;
    trap_d  = strobe_i & (|hits_i);
    cause_d = '0;
    if (trap_d) begin
      cause_d.cls = CLASS_PROGRAM;
      cause_d.sub = SUB_TRAP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      trap_q  <= 1'b0;
      cause_q <= '0;
    end else begin
      valid_q <= valid_d;
      trap_q  <= trap_d;
      cause_q <= cause_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hits_q <= '0;
    end else if (hits_en) begin
      hits_q <= hits_i;
    end
  end

  assign resp_valid_o = valid_q;
  assign trap_o       = trap_q;
  assign cause_o      = cause_q;
  assign hits_o       = hits_q;
endmodule

// File: rtl/tcmp_trap_cmp.sv
module tcmp_trap_cmp
  import tcmp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic              dword_i,
  input  logic [4:0]        cond_mask_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  output logic              resp_valid_o,
  output logic              trap_o,
  output logic [7:0]        trap_cause_o,
  output logic [4:0]        rel_hits_o
);
  localparam int EXT_W  = DATA_W + 1;
  localparam int N_OPND = 2;

  logic [N_OPND-1:0][DATA_W-1:0] opnd;
  logic [N_OPND-1:0][EXT_W-1:0]  opnd_sx;
  logic [N_OPND-1:0][EXT_W-1:0]  opnd_zx;
  logic [REL_W-1:0]              rel;
  logic [REL_W-1:0]              hits;
  trap_cause_t                   cause;

  assign opnd[0] = op_a_i;
  assign opnd[1] = op_b_i;

  for (genvar g = 0; g < N_OPND; g++) begin : g_fmt
    tcmp_operand_fmt #(
      .DATA_W (DATA_W),
      .WORD_W (WORD_W)
    ) u_fmt (
      .dword_i (dword_i),
      .op_i    (opnd[g]),
      .sx_o    (opnd_sx[g]),
      .zx_o    (opnd_zx[g])
    );
  end

  tcmp_relation_unit #(
    .EXT_W (EXT_W)
  ) u_rel (
    .a_sx_i (opnd_sx[0]),
    .b_sx_i (opnd_sx[1]),
    .a_zx_i (opnd_zx[0]),
    .b_zx_i (opnd_zx[1]),
    .rel_o  (rel)
  );

  assign hits = rel & cond_mask_i;

  tcmp_result_reg u_res (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe_i     (req_valid_i),
    .hits_i       (hits),
    .resp_valid_o (resp_valid_o),
    .trap_o       (trap_o),
    .cause_o      (cause),
    .hits_o       (rel_hits_o)
  );

  assign trap_cause_o = cause;
endmodule

// File: rtl/tcmp_trap_cmp_chk.sv
module tcmp_trap_cmp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid_i,
  input logic [4:0] cond_mask_i,
  input logic       resp_valid_o,
  input logic       trap_o,
  input logic [7:0] trap_cause_o,
  input logic [4:0] rel_hits_o
);
  p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> resp_valid_o);
  p_no_spurious_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> !resp_valid_o);
  p_pulse_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> resp_valid_o);
  p_cause_on_trap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> trap_cause_o == 8'h62);
  p_cause_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_o |-> trap_cause_o == 8'h00);
  p_zero_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && cond_mask_i == 5'h00) |=> !trap_o);
  p_full_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && cond_mask_i == 5'h1f) |=> trap_o);
  p_signed_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rel_hits_o[4:2]) <= 1);
  p_unsigned_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rel_hits_o[1] && rel_hits_o[0]));
  p_hits_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> $stable(rel_hits_o));
endmodule

bind tcmp_trap_cmp tcmp_trap_cmp_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid_i  (req_valid_i),
  .cond_mask_i  (cond_mask_i),
  .resp_valid_o (resp_valid_o),
  .trap_o       (trap_o),
  .trap_cause_o (trap_cause_o),
  .rel_hits_o   (rel_hits_o)
);

// File: tb/tcmp_trap_cmp_test.sv
`timescale 1ns/1ps
module tcmp_trap_cmp_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        dword;
  logic [4:0]  mask;
  logic [63:0] op_a, op_b;
  logic        resp_valid, trap;
  logic [7:0]  cause;
  logic [4:0]  hits;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tcmp_trap_cmp uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid),
    .dword_i      (dword),
    .cond_mask_i  (mask),
    .op_a_i       (op_a),
    .op_b_i       (op_b),
    .resp_valid_o (resp_valid),
    .trap_o       (trap),
    .trap_cause_o (cause),
    .rel_hits_o   (hits)
  );

  // relation bits: [4] signed lt, [3] signed gt, [2] eq, [1] unsigned lt, [0] unsigned gt
  function automatic logic [4:0] ref_rel(bit dw, logic [63:0] a, logic [63:0] b);
    longint      sa, sb;
    logic [63:0] ua, ub;
    if (dw) begin
      sa = a; sb = b; ua = a; ub = b;
    end else begin
      sa = longint'($signed(a[31:0]));
      sb = longint'($signed(b[31:0]));
      ua = {32'd0, a[31:0]};
      ub = {32'd0, b[31:0]};
    end
    return {sa < sb, sa > sb, ua == ub, ua < ub, ua > ub};
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one strobe; sample its registered result one edge later
  task automatic issue(bit dw, logic [4:0] m, logic [63:0] a, logic [63:0] b, string tag);
    logic [4:0] eh;
    bit         et;
    eh = ref_rel(dw, a, b) & m;
    et = |eh;
    @(negedge clk);
    req_valid = 1'b1; dword = dw; mask = m; op_a = a; op_b = b;
    @(posedge clk); #1;
    check(resp_valid === 1'b1, "R8 valid", resp_valid, 1);
    check(trap === et, tag, trap, et);
    check(hits === eh, "R11 hits", hits, eh);
    check(cause === (et ? 8'h62 : 8'h00), "R9 cause", cause, et ? 8'h62 : 8'h00);
  endtask

  task automatic idle_check(logic [4:0] held);
    @(negedge clk);
    req_valid = 1'b0; op_a = '1; op_b = '0; mask = 5'h1f;
    @(posedge clk); #1;
    check(resp_valid === 1'b0, "R8 idle valid", resp_valid, 0);
    check(trap === 1'b0, "R8 single pulse", trap, 0);
    check(hits === held, "R11 hold", hits, held);
    check(cause === 8'h00, "R9 idle cause", cause, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; dword = 1'b0; mask = '0; op_a = '0; op_b = '0;
    repeat (3) @(posedge clk);
    #1;
    check(resp_valid === 1'b0 && trap === 1'b0, "R1 reset flags", {resp_valid, trap}, 0);
    check(cause === 8'h00, "R1 reset cause", cause, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check(trap === 1'b0 && resp_valid === 1'b0, "R1 after release", {resp_valid, trap}, 0);

    // directed relations, word mode
    issue(0, 5'h10, 64'hFFFF_FFFF, 64'h1, "R2 signed lt -1<1");
    issue(0, 5'h01, 64'hFFFF_FFFF, 64'h1, "R5 unsigned gt");
    issue(0, 5'h08, 64'h1, 64'hFFFF_FFFF, "R3 signed gt");
    issue(0, 5'h02, 64'h1, 64'hFFFF_FFFF, "R5 unsigned lt");
    issue(0, 5'h04, 64'h1234, 64'h1234, "R4 equal");
    issue(0, 5'h0b, 64'h1234, 64'h1234, "R4 no eq bit");
    idle_check(5'h00);
    // word mode ignores upper halves
    issue(0, 5'h04, 64'hDEAD_0000_0000_0005, 64'h0000_BEEF_0000_0005, "R6 upper ignored eq");
    issue(0, 5'h1b, 64'hDEAD_0000_0000_0005, 64'h0000_BEEF_0000_0005, "R6 upper ignored ne");
    // doubleword mode uses full width
    issue(1, 5'h04, 64'hDEAD_0000_0000_0005, 64'h0000_BEEF_0000_0005, "R7 full eq");
    issue(1, 5'h10, 64'h8000_0000_0000_0000, 64'h0, "R7 sign bit63");
    issue(1, 5'h01, 64'h8000_0000_0000_0000, 64'h0, "R7 unsigned bit63");
    issue(1, 5'h10, 64'h0000_0000_8000_0000, 64'h0, "R7 bit31 positive");
    // mask extremes
    issue(1, 5'h00, 64'h5, 64'h9, "R10 zero mask");
    issue(0, 5'h1f, 64'h7, 64'h7, "R10 full mask eq");
    issue(1, 5'h1f, 64'h3, 64'h9, "R10 full mask lt");
    idle_check(ref_rel(1, 64'h3, 64'h9));

    // random, back to back
    void'($urandom(32'd4242));
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      case ($urandom % 4)
        0: b = a;
        1: b = {b[63:32], a[31:0]};
        2: b = a ^ (64'h1 << ($urandom % 64));
        default: ;
      endcase
      issue($urandom % 2, 5'($urandom), a, b, "R2 R3 R4 R5 random");
      if ((i % 37) == 0) idle_check(hits);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule